// File: doc/BRIEF.md
# Sixteen-bit timer/counter with prescaler

This block is a 16-bit up-counter read and written as two byte registers. It has two count sources. In timer mode it counts a single-cycle internal tick, which runs at one quarter of the oscillator rate. In counter mode it counts rising edges of an external clock pin, after a divider that passes one edge in 1, 2, 4 or 8. When the count rolls over from all ones to zero, a sticky overflow flag is set, and software clears it.

In counter mode the divided external pulse can take one of two paths to the count. It can go straight to the count (unsynchronized mode), or it can first pass through a two-flop synchronizer with rising-edge detection (synchronized mode). While the sleep input is high, the synchronized path and the internal tick both stop. The divider keeps dividing external edges during sleep, and the unsynchronized path keeps counting. After the block is enabled in counter mode it needs one falling edge on the pin before it counts a rising edge. The external pin is sampled once by the system clock, so the divider runs on those sampled edges.

Top module: `tmr16_top`

## Requirements
- R1: While reset is held, the count reads 0x0000 and the overflow flag is 0.
- R2: In timer mode (`src_ext` = 0) with `run_en` = 1 and no sleep, each single-cycle `tick_int` pulse adds one to the count on the next clock edge. The `async_mode` input has no effect in this mode.
- R3: While `run_en` = 0, neither ticks nor external edges change the count.
- R4: In counter mode (`src_ext` = 1) the count advances on rising edges of `ext_clk`. After `run_en` or `src_ext` is set, rising edges are ignored until a falling edge of `ext_clk` has been seen. A pin idling high must therefore fall before anything is counted.
- R5: `div_sel` values 0, 1, 2 and 3 give division ratios of 1, 2, 4 and 8. Starting from a cleared divider, the first increment comes on the N-th counted rising edge, where N is the ratio.
- R6: In unsynchronized mode (`async_mode` = 1), a rising edge driven on `ext_clk` shows in the count two clock edges after it is sampled. In synchronized mode (`async_mode` = 0) it shows two edges later than that. The count never changes by more than one per clock unless it is written.
- R7: In synchronized counter mode with `sleep` = 1, the count holds. The divider keeps counting external edges, so after wake-up the first increment comes on the edge that completes the ratio begun during sleep.
- R8: In unsynchronized counter mode the count keeps advancing while `sleep` = 1.
- R9: An increment from 0xFFFF to 0x0000 sets `ovf_flag`, and the flag stays set until `ovf_clr` is pulsed. If `ovf_clr` and a new overflow fall in the same cycle, the flag stays set.
- R10: `wr_lo` loads `wr_data` into bits 7:0 and `wr_hi` loads it into bits 15:8. A write wins over an increment in the same cycle and clears the divider. A change of `div_sel` also clears the divider.
- R11: In timer mode with `sleep` = 1, ticks do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal quarter-rate tick, one cycle wide |
| ext_clk | input | 1 | External clock pin, asynchronous |
| run_en | input | 1 | Counting enable |
| src_ext | input | 1 | Source select: 0 timer, 1 external counter |
| async_mode | input | 1 | 1 bypasses the synchronizer in counter mode |
| div_sel | input | 2 | Divider select: ratio 1, 2, 4, 8 |
| sleep | input | 1 | Sleep state |
| wr_lo | input | 1 | Write strobe for the low count byte |
| wr_hi | input | 1 | Write strobe for the high count byte |
| wr_data | input | 8 | Byte written to the count |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_lo | output | 8 | Count bits 7:0 |
| cnt_hi | output | 8 | Count bits 15:8 |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can land on the same clock edge: an overflow clear with a rollover, and a byte write with an increment. The bench provokes each pair by driving `ovf_clr` or `wr_lo` in the same cycle as a `tick_int` pulse. The count must then take the written byte, and the flag must read set. The divider clear is tested the same way: a write made partway through a ratio of four must make the next edge count from zero. The sleep case is judged by how many edges are needed after wake-up.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_EXT  = 1'b1
  } src_sel_e;
endpackage

// File: rtl/tmr16_ext_edge.sv
// Samples the external pin and reports rising edges once a falling edge has armed it.
module tmr16_ext_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pin,
  input  logic arm_en,
  output logic rise_armed
);
  logic ext_q, ext_prev, armed_q;
  logic armed_d, fall_seen, rise_seen;

  assign rise_seen = ext_q & ~ext_prev;
  assign fall_seen = ~ext_q & ext_prev;

  always_comb begin
    if (!arm_en) armed_d = 1'b0;
    else         armed_d = armed_q | fall_seen;
  end

  assign rise_armed = armed_q & rise_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q    <= 1'b0;
      ext_prev <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      ext_q    <= ext_pin;
      ext_prev <= ext_q;
      armed_q  <= armed_d;
    end
  end
endmodule

// File: rtl/tmr16_prescale.sv
// Edge divider: emits one pulse per 2**sel input edges; cleared on request or select change.
module tmr16_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_in,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse_out
);
  localparam int STAGES = (1 << SEL_W) - 1;

  logic [STAGES-1:0] div_q, div_d, mask;
  logic [SEL_W-1:0]  sel_q;
  logic              restart, div_en;

  always_comb begin
    mask = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (i < int'(sel)) mask[i] = 1'b1;
    end
  end

  assign restart   = clr | (sel != sel_q);
  assign pulse_out = edge_in & ~restart & ((div_q & mask) == mask);
  assign div_en    = restart | edge_in;

  always_comb begin
    if (restart) div_d = '0;
    else         div_d = (div_q + 1'b1) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel;
      if (div_en) div_q <= div_d;
    end
  end
endmodule

// File: rtl/tmr16_sync.sv
// Multi-flop synchronizer with rising-edge detect; input forced low and output gated in sleep.
module tmr16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic sleep,
  output logic inc_out
);
  logic [STAGES-1:0] stg_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= 1'b0;
    else        stg_q[0] <= pulse_in & ~sleep;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= 1'b0;
      else        stg_q[g] <= stg_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= stg_q[STAGES-1];
  end

  assign inc_out = stg_q[STAGES-1] & ~last_q & ~sleep;
endmodule

// File: rtl/tmr16_count.sv
// Byte-writable up-counter with sticky rollover flag.
module tmr16_count #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inc,
  input  logic [NBYTES-1:0]        wr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     ovf_clr,
  output logic [NBYTES*BYTE_W-1:0] cnt,
  output logic                     ovf_flag
);
  localparam int CNT_W = NBYTES * BYTE_W;

  logic [CNT_W-1:0] cnt_d, cnt_inc;
  logic             any_wr, cnt_en, ovf_evt, flag_d;

  assign any_wr  = |wr;
  assign cnt_inc = cnt + 1'b1;
  assign cnt_en  = any_wr | inc;
  assign ovf_evt = inc & ~any_wr & (&cnt);
  assign flag_d  = ovf_evt | (ovf_flag & ~ovf_clr);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign cnt_d[g*BYTE_W +: BYTE_W] =
      wr[g]  ? wr_data :
      any_wr ? cnt[g*BYTE_W +: BYTE_W] :
               cnt_inc[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (cnt_en) cnt <= cnt_d;
      ovf_flag <= flag_d;
    end
  end
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top #(
  parameter int BYTE_W      = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_int,
  input  logic              ext_clk,
  input  logic              run_en,
  input  logic              src_ext,
  input  logic              async_mode,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              sleep,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag
);
  import tmr16_pkg::*;

  localparam int NBYTES = 2;
  localparam int CNT_W  = NBYTES * BYTE_W;

  src_sel_e         src;
  logic             ext_rise, pre_pulse, sync_inc;
  logic             inc_tick, inc_ext, inc;
  logic [NBYTES-1:0] wr_vec;
  logic [CNT_W-1:0] cnt;

  assign src    = src_sel_e'(src_ext);
  assign wr_vec = {wr_hi, wr_lo};

  tmr16_ext_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_pin    (ext_clk),
    .arm_en     (run_en & (src == SRC_EXT)),
    .rise_armed (ext_rise)
  );

  tmr16_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_in   (ext_rise),
    .clr       (|wr_vec),
    .sel       (div_sel),
    .pulse_out (pre_pulse)
  );

  tmr16_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_in (pre_pulse),
    .sleep    (sleep),
    .inc_out  (sync_inc)
  );

  assign inc_tick = (src == SRC_TICK) & tick_int & ~sleep;
  assign inc_ext  = (src == SRC_EXT) & (async_mode ? pre_pulse : sync_inc);
  assign inc      = run_en & (inc_tick | inc_ext);

  tmr16_count #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .wr       (wr_vec),
    .wr_data  (wr_data),
    .ovf_clr  (ovf_clr),
    .cnt      (cnt),
    .ovf_flag (ovf_flag)
  );

  assign cnt_lo = cnt[BYTE_W-1:0];
  assign cnt_hi = cnt[CNT_W-1:BYTE_W];
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              src_ext,
  input logic              async_mode,
  input logic              sleep,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic [BYTE_W-1:0] wr_data,
  input logic              ovf_clr,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              ovf_flag
);
  logic [2*BYTE_W-1:0] cnt;
  logic                no_wr;
  assign cnt   = {cnt_hi, cnt_lo};
  assign no_wr = ~wr_lo & ~wr_hi;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0 && !ovf_flag));

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && no_wr) |=> $stable(cnt));

  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    no_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R7 and R11: sleep freezes every path except unsynchronized counting
  p_sleep_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !(src_ext && async_mode) && no_wr) |=> $stable(cnt));

  p_rollover_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (no_wr && (&cnt)) |=> (cnt != '0 || ovf_flag));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_write_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(wr_data)));

  p_write_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_hi == $past(wr_data)));
endmodule

bind tmr16_top tmr16_checker #(.BYTE_W(BYTE_W)) u_tmr16_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .src_ext    (src_ext),
  .async_mode (async_mode),
  .sleep      (sleep),
  .wr_lo      (wr_lo),
  .wr_hi      (wr_hi),
  .wr_data    (wr_data),
  .ovf_clr    (ovf_clr),
  .cnt_lo     (cnt_lo),
  .cnt_hi     (cnt_hi),
  .ovf_flag   (ovf_flag)
);

// File: tb/tmr16_top_test.sv
module tmr16_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, tick_int, ext_clk, run_en, src_ext, async_mode;
  logic [1:0] div_sel;
  logic       sleep, wr_lo, wr_hi, ovf_clr;
  logic [7:0] wr_data, cnt_lo, cnt_hi;
  logic       ovf_flag;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    int          kind;   // 0 = count, 1 = flag
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  tmr16_top uut (
    .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .ext_clk(ext_clk),
    .run_en(run_en), .src_ext(src_ext), .async_mode(async_mode),
    .div_sel(div_sel), .sleep(sleep), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb_q.pop_front();
      act = (it.kind == 0) ? {cnt_hi, cnt_lo} : {15'd0, ovf_flag};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic chk(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    step();
  endtask

  task automatic tick;
    tick_int = 1'b1; step(); tick_int = 1'b0; step();
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (3) step();
      ext_clk = 1'b0; repeat (3) step();
    end
  endtask

  task automatic wr_byte(input bit hi, input logic [7:0] d);
    wr_data = d;
    if (hi) wr_hi = 1'b1; else wr_lo = 1'b1;
    step();
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick_int = 0; ext_clk = 0; run_en = 0; src_ext = 0;
    async_mode = 0; div_sel = 0; sleep = 0; wr_lo = 0; wr_hi = 0;
    wr_data = 0; ovf_clr = 0;
    repeat (3) step();
    chk(0, 16'h0000, "R1 count in reset");
    chk(1, 16'h0000, "R1 flag in reset");
    rst_n = 1; step();

    // R2 timer mode, sync bypass irrelevant
    run_en = 1;
    repeat (3) tick();
    chk(0, 16'd3, "R2 three ticks");
    async_mode = 1;
    repeat (2) tick();
    chk(0, 16'd5, "R2 ticks with bypass set");

    // R3 disabled
    run_en = 0;
    repeat (2) tick();
    chk(0, 16'd5, "R3 ticks while disabled");

    // R11 sleep in timer mode
    run_en = 1; sleep = 1;
    repeat (2) tick();
    chk(0, 16'd5, "R11 ticks during sleep");
    sleep = 0; step();

    // R10 write beats tick in the same cycle
    tick_int = 1'b1; wr_byte(0, 8'h34); tick_int = 1'b0; step();
    wr_byte(1, 8'h12); step();
    chk(0, 16'h1234, "R10 byte writes with tick collision");
    wr_byte(0, 8'h00); wr_byte(1, 8'h00); step();

    // R4 arming on falling edge
    src_ext = 1; async_mode = 1; div_sel = 0;
    run_en = 0; step(); run_en = 1; step();
    pulse(1);
    chk(0, 16'd0, "R4 first rise ignored before a fall");
    pulse(2);
    chk(0, 16'd2, "R4 rises counted after arming");
    run_en = 0; step();
    ext_clk = 1; repeat (2) step();
    run_en = 1; repeat (3) step();
    chk(0, 16'd2, "R4 idle-high pin does not count");
    ext_clk = 0; repeat (3) step();
    pulse(1);
    chk(0, 16'd3, "R4 counts after fall from idle high");

    // R6 latency, unsynchronized then synchronized
    ext_clk = 1; step();
    chk(0, 16'd4, "R6 unsynchronized latency");
    ext_clk = 0; repeat (3) step();
    async_mode = 0; step();
    ext_clk = 1; step();
    chk(0, 16'd4, "R6 synchronized not yet (1)");
    chk(0, 16'd4, "R6 synchronized not yet (2)");
    chk(0, 16'd5, "R6 synchronized latency");
    ext_clk = 0; repeat (3) step();

    // R5 division ratios
    async_mode = 1;
    wr_byte(0, 8'h00); step();
    div_sel = 3; step();
    pulse(7);
    chk(0, 16'd0, "R5 ratio 8 before eighth edge");
    pulse(1);
    chk(0, 16'd1, "R5 ratio 8 on eighth edge");
    div_sel = 1; step();
    pulse(1);
    chk(0, 16'd1, "R5 ratio 2 first edge");
    pulse(1);
    chk(0, 16'd2, "R5 ratio 2 second edge");
    div_sel = 2; step();
    pulse(4);
    chk(0, 16'd3, "R5 ratio 4");

    // R10 divider cleared by write and by select change
    pulse(3);
    wr_byte(0, 8'h10); step();
    pulse(1);
    chk(0, 16'h0010, "R10 write cleared divider");
    pulse(3);
    chk(0, 16'h0011, "R10 ratio restarts after write");
    pulse(3);
    div_sel = 1; step(); div_sel = 2; step();
    pulse(1);
    chk(0, 16'h0011, "R10 select change cleared divider");
    pulse(3);
    chk(0, 16'h0012, "R10 ratio restarts after select change");

    // R7 synchronized sleep: count holds, divider runs
    async_mode = 0; div_sel = 1; step();
    sleep = 1; step();
    pulse(3);
    chk(0, 16'h0012, "R7 count frozen in sleep");
    sleep = 0; step();
    pulse(1);
    chk(0, 16'h0013, "R7 divider advanced during sleep");

    // R8 unsynchronized counting in sleep
    async_mode = 1; div_sel = 0; step();
    sleep = 1; step();
    pulse(1);
    chk(0, 16'h0014, "R8 counts during sleep");
    sleep = 0; step();

    // R9 overflow flag
    src_ext = 0; step();
    wr_byte(1, 8'hFF); wr_byte(0, 8'hFF); step();
    chk(1, 16'd0, "R9 flag clear before rollover");
    tick();
    chk(0, 16'h0000, "R9 rollover to zero");
    chk(1, 16'd1, "R9 flag set by rollover");
    tick();
    chk(1, 16'd1, "R9 flag sticky");
    ovf_clr = 1; step(); ovf_clr = 0; step();
    chk(1, 16'd0, "R9 flag cleared");
    wr_byte(1, 8'hFF); wr_byte(0, 8'hFF); step();
    ovf_clr = 1; tick_int = 1; step(); ovf_clr = 0; tick_int = 0; step();
    chk(1, 16'd1, "R9 clear and overflow same cycle");

    step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule